// File: doc/BRIEF.md
# Battery-Backed Byte Memory Access Gate

This block is a clocked model of a byte-wide static memory that keeps its contents on a backup cell. A host drives active-low chip, output and write enables, an address and a data byte. On every clock the gate decides whether the sampled bus state is a read, a write, or something to ignore. Its supply and battery state arrive as already-digitised flags. Data leaves on a separate output byte with its own drive-enable, so the usual shared data bus is modelled without tri-states.

Three protections sit between the bus and the array:
- **Supply-fail guard.** It ignores every access while the supply flag is low, and for a recovery period after the supply returns.
- **Manual read-only switch.** It turns the memory into a read-only store.
- **Low-battery probe.** When both backup cells were reported weak at the moment power came back, the second memory cycle after power-up is dropped. A host can detect this by writing a location and reading it back. An address check flags accesses that set bits above the fitted capacity.

Top module: `bbsram_gate`

## Requirements
- R1: `dout_en` is high on the clock after a cycle in which `ce_n`=0, `we_n`=1, `oe_n`=0 and the gate is ready. While `dout_en` is low, `dout` reads all zeros. Out of reset both `dout_en` and `addr_err` are 0.
- R2: A read returns the byte stored at the low `USED_AW` address bits. When a write completes on the same clock edge that samples the read of that address, the read returns the newly written byte.
- R3: A write pulse holds while `ce_n`=0 and `we_n`=0. It completes on the first clock at which either enable is seen high again, and then stores the address and byte sampled on the last clock of the pulse.
- R4: When `we_n` is sampled low, `dout_en` is low on the next clock, and it stays low for as long as the pulse lasts.
- R5: While `supply_ok`=0 nothing is driven and nothing is stored. A write pulse that is cut off by the supply dropping is discarded.
- R6: With `protect_sw`=1 at the clock where a write would complete, the write is discarded. Reads behave normally.
- R7: The clock at which `supply_ok` is first seen high, plus the following `REC_CYC` clocks, form a recovery window in which every access is ignored.
- R8: A memory cycle begins on the first ready clock with `ce_n`=0. If both `batt_a_ok` and `batt_b_ok` were 0 when the supply returned, the second cycle after that return is dropped whole. Its read drives nothing and its write stores nothing. The first and third cycles behave normally.
- R9: If either battery flag was 1 when the supply returned, no cycle is dropped.
- R10: `addr_err` is high on the clock after a cycle with `ce_n`=0 and any address bit at or above position `USED_AW` set. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| supply_ok | input | 1 | Supply above the write threshold |
| batt_a_ok | input | 1 | First backup cell above its warning level |
| batt_b_ok | input | 1 | Second backup cell above its warning level |
| protect_sw | input | 1 | Manual read-only switch |
| dout | output | DATA_W | Read data |
| dout_en | output | 1 | Read data is being driven |
| addr_err | output | 1 | Unused high address bit set during an access |

## Verification
Completing a write and serving a read can land on the same clock edge. This happens when `we_n` rises while `ce_n` and `oe_n` stay low on the same address. The bench provokes it and expects the fresh byte on `dout` one clock later, not the stale array content. A dropped second cycle can also coincide with a write request. The bench places a write in that slot after a weak-battery power-up and judges it by reading the address back on the third cycle, which must show the old byte. A behavioural model in the bench predicts `dout_en`, `dout` and `addr_err` on every clock.

// File: rtl/bbsram_pkg.sv
`timescale 1ns/1ps
package bbsram_pkg;

  // How many memory cycles have begun since the supply returned (saturating).
  typedef enum logic [1:0] {
    SEEN_NONE  = 2'd0,
    SEEN_ONE   = 2'd1,
    SEEN_MANY  = 2'd2
  } cyc_seen_t;

  // Both backup cells weak: the probe window is armed.
  function automatic logic cells_both_weak(input logic a_ok, input logic b_ok);
    return !(a_ok || b_ok);
  endfunction

  // Any address bit at or above the fitted width is set.
  function automatic logic beyond_fitted(input logic [31:0] a, input int unsigned fitted_w);
    return (a >> fitted_w) != 32'd0;
  endfunction

  // Next value of the saturating cycle tally.
  function automatic cyc_seen_t seen_next(input cyc_seen_t s);
    case (s)
      SEEN_NONE: return SEEN_ONE;
      default:   return SEEN_MANY;
    endcase
  endfunction

endpackage

// File: rtl/bbsram_power.sv
`timescale 1ns/1ps
module bbsram_power
  import bbsram_pkg::*;
#(
  parameter int REC_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic batt_a_ok,
  input  logic batt_b_ok,
  input  logic ce_n,
  output logic acc,
  output logic inhibit,
  output logic batt_low
);
  localparam int REC_W = $clog2(REC_CYC + 1);

  logic             supply_q;
  logic [REC_W-1:0] rec_cnt;
  cyc_seen_t        seen_q;
  logic             acc_q;
  logic             inh_q;

  logic pwr_up;
  logic ready;
  logic cyc_start;
  logic probe_hit;

  assign pwr_up    = supply_ok & ~supply_q;
  assign ready     = supply_ok & ~pwr_up & (rec_cnt == '0);
  assign acc       = ready & ~ce_n;
  assign cyc_start = acc & ~acc_q;
  assign probe_hit = cyc_start & (seen_q == SEEN_ONE) & batt_low;
  assign inhibit   = cyc_start ? probe_hit : (acc & inh_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      supply_q <= 1'b0;
      rec_cnt  <= '0;
      batt_low <= 1'b0;
      seen_q   <= SEEN_NONE;
      acc_q    <= 1'b0;
      inh_q    <= 1'b0;
    end else begin
      supply_q <= supply_ok;
      acc_q    <= acc;
      inh_q    <= inhibit;
      if (pwr_up) begin
        rec_cnt  <= REC_W'(REC_CYC);
        batt_low <= cells_both_weak(batt_a_ok, batt_b_ok);
        seen_q   <= SEEN_NONE;
      end else begin
        if (rec_cnt != '0) rec_cnt <= rec_cnt - 1'b1;
        if (cyc_start) seen_q <= seen_next(seen_q);
      end
    end
  end

  // The recovery window opens on the supply-return clock.
  assert_recovery_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_up |=> !acc);

endmodule

// File: rtl/bbsram_bus.sv
`timescale 1ns/1ps
module bbsram_bus #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          inhibit,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          supply_ok,
  input  logic          protect_sw,
  input  logic [AW-1:0] addr_lo,
  input  logic [DW-1:0] din,
  output logic          rd_now,
  output logic          wr_now,
  output logic          commit,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic wr_q;

  assign rd_now = acc & we_n & ~oe_n & ~inhibit;
  assign wr_now = acc & ~we_n & ~inhibit;
  assign commit = wr_q & ~wr_now & supply_ok & ~protect_sw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_q <= wr_now;
      if (wr_now) begin
        wr_addr <= addr_lo;
        wr_data <= din;
      end
    end
  end

  // A store only follows a clock at which the write pulse was sampled.
  assert_commit_after_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(!we_n && acc));

endmodule

// File: rtl/bbsram_array.sv
`timescale 1ns/1ps
module bbsram_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_now,
  input  logic [AW-1:0] rd_addr,
  input  logic          commit,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] dout,
  output logic          dout_en
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];
  logic          same_slot;
  logic [DW-1:0] rd_val;

  assign same_slot = commit && (wr_addr == rd_addr);
  assign rd_val    = same_slot ? wr_data : cells[rd_addr];

  always_ff @(posedge clk) begin
    if (commit) cells[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      dout_en <= rd_now;
      dout    <= rd_now ? rd_val : '0;
    end
  end

endmodule

// File: rtl/bbsram_gate.sv
`timescale 1ns/1ps
module bbsram_gate
  import bbsram_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int USED_AW = 11,
  parameter int DATA_W  = 8,
  parameter int REC_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              supply_ok,
  input  logic              batt_a_ok,
  input  logic              batt_b_ok,
  input  logic              protect_sw,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              addr_err
);
  logic               acc;
  logic               inhibit;
  logic               batt_low;
  logic               rd_now;
  logic               wr_now;
  logic               commit;
  logic [USED_AW-1:0] addr_lo;
  logic [USED_AW-1:0] wr_addr;
  logic [DATA_W-1:0]  wr_data;
  logic               upper_hit;

  assign addr_lo = addr[USED_AW-1:0];

  generate
    if (USED_AW < ADDR_W) begin : g_partial
      assign upper_hit = beyond_fitted(32'(addr), USED_AW);
    end else begin : g_full
      assign upper_hit = 1'b0;
    end
  endgenerate

  bbsram_power #(.REC_CYC(REC_CYC)) u_power (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
    .batt_a_ok(batt_a_ok), .batt_b_ok(batt_b_ok), .ce_n(ce_n),
    .acc(acc), .inhibit(inhibit), .batt_low(batt_low)
  );

  bbsram_bus #(.AW(USED_AW), .DW(DATA_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .acc(acc), .inhibit(inhibit),
    .we_n(we_n), .oe_n(oe_n), .supply_ok(supply_ok), .protect_sw(protect_sw),
    .addr_lo(addr_lo), .din(din),
    .rd_now(rd_now), .wr_now(wr_now), .commit(commit),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  bbsram_array #(.AW(USED_AW), .DW(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n), .rd_now(rd_now), .rd_addr(addr_lo),
    .commit(commit), .wr_addr(wr_addr), .wr_data(wr_data),
    .dout(dout), .dout_en(dout_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_err <= 1'b0;
    else        addr_err <= ~ce_n & upper_hit;
  end

  assert_read_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> $past(!ce_n && we_n && !oe_n && supply_ok));

  assert_we_blanks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |=> !dout_en);

  assert_unpowered_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!dout_en && !commit));

  assert_probe_drops_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> !dout_en);

  assert_probe_drops_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> !commit);

  assert_good_cell_no_probe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !batt_low |-> !inhibit);

  assert_no_write_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_now |-> !rd_now);

endmodule

// File: tb/sim_bbsram_gate.sv
`timescale 1ns/1ps
module sim_bbsram_gate;
  localparam int AW  = 15;
  localparam int UAW = 11;
  localparam int DW  = 8;
  localparam int REC = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic supply_ok = 1'b1, batt_a_ok = 1'b1, batt_b_ok = 1'b1, protect_sw = 1'b0;
  logic [DW-1:0] dout;
  logic dout_en, addr_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bbsram_gate #(.ADDR_W(AW), .USED_AW(UAW), .DATA_W(DW), .REC_CYC(REC)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .supply_ok(supply_ok), .batt_a_ok(batt_a_ok),
    .batt_b_ok(batt_b_ok), .protect_sw(protect_sw),
    .dout(dout), .dout_en(dout_en), .addr_err(addr_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [7:0] m_mem [int];
  int   m_rec, m_seen, m_wa;
  bit   m_supq, m_low, m_accq, m_inhq, m_wrq;
  logic [7:0] m_wd;
  bit   exp_en, exp_err, exp_cmp;
  logic [7:0] exp_d;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mem.delete();
      m_rec = 0; m_seen = 0; m_wa = 0; m_wd = 0;
      m_supq = 0; m_low = 0; m_accq = 0; m_inhq = 0; m_wrq = 0;
      exp_en = 0; exp_err = 0; exp_cmp = 1; exp_d = 0;
    end else begin
      bit rise, ok, acc, start, inh, wr, rd, cm;
      int a;
      a     = int'(addr % (1 << UAW));
      rise  = supply_ok && !m_supq;
      ok    = supply_ok && !rise && (m_rec == 0);
      acc   = ok && !ce_n;
      start = acc && !m_accq;
      if (start) inh = (m_seen == 1) && m_low;
      else       inh = acc && m_inhq;
      wr = acc && !we_n && !inh;
      rd = acc && we_n && !oe_n && !inh;
      cm = m_wrq && !wr && supply_ok && !protect_sw;
      exp_en  = rd;
      exp_err = !ce_n && ((int'(addr) >> UAW) != 0);
      if (!rd) begin exp_d = 0; exp_cmp = 1; end
      else if (cm && m_wa == a) begin exp_d = m_wd; exp_cmp = 1; end
      else if (m_mem.exists(a)) begin exp_d = m_mem[a]; exp_cmp = 1; end
      else exp_cmp = 0;
      if (cm) m_mem[m_wa] = m_wd;
      if (wr) begin m_wa = a; m_wd = din; end
      m_wrq = wr; m_accq = acc; m_inhq = inh; m_supq = supply_ok;
      if (rise) begin
        m_rec = REC; m_low = !(batt_a_ok || batt_b_ok); m_seen = 0;
      end else begin
        if (m_rec > 0) m_rec--;
        if (start && m_seen < 2) m_seen++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 model drive", dout_en, exp_en);
      chk("R10 model addr flag", addr_err, exp_err);
      if (exp_cmp) chk("R2 model data", dout, exp_d);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic drive(input logic c, input logic o, input logic w,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w; addr = a; din = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, 1'b1, 1'b1, '0, '0);
  endtask

  task automatic sample();
    @(posedge clk);
    #2;
  endtask

  task automatic power_cycle(input logic a_ok, input logic b_ok);
    idle(1);
    @(negedge clk); supply_ok = 1'b0;
    idle(3);
    @(negedge clk); batt_a_ok = a_ok; batt_b_ok = b_ok; supply_ok = 1'b1;
    idle(REC + 4);
  endtask

  task automatic read_at(input logic [AW-1:0] a);
    drive(1'b0, 1'b0, 1'b1, a, '0);
    sample();
  endtask

  task automatic write_at(input logic [AW-1:0] a, input logic [DW-1:0] d);
    drive(1'b0, 1'b1, 1'b0, a, d);
    drive(1'b1, 1'b1, 1'b1, a, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R1 reset drive", dout_en, 1'b0);
    chk("R10 reset flag", addr_err, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // R7: access inside the recovery window is ignored
    read_at(15'd5);
    chk("R7 recovery read", dout_en, 1'b0);
    idle(REC + 4);

    // R3 / R2: basic store and fetch
    write_at(15'd5, 8'hA5);
    read_at(15'd5);
    chk("R2 read drive", dout_en, 1'b1);
    chk("R3 stored byte", dout, 8'hA5);
    idle(1);

    // R3: last sampled byte of a long pulse is kept
    drive(1'b0, 1'b1, 1'b0, 15'd7, 8'h11);
    drive(1'b0, 1'b1, 1'b0, 15'd7, 8'h22);
    drive(1'b1, 1'b1, 1'b1, 15'd7, 8'h33);
    read_at(15'd7);
    chk("R3 last byte", dout, 8'h22);
    idle(1);

    // R2: completion and read of the same byte on one edge
    drive(1'b0, 1'b0, 1'b0, 15'd9, 8'h3C);
    drive(1'b0, 1'b0, 1'b1, 15'd9, 8'h00);
    sample();
    chk("R2 same-edge drive", dout_en, 1'b1);
    chk("R2 same-edge byte", dout, 8'h3C);
    idle(1);

    // R4: write enable falls during a read
    read_at(15'd5);
    chk("R4 read before", dout_en, 1'b1);
    drive(1'b0, 1'b0, 1'b0, 15'd5, 8'h77);
    sample();
    chk("R4 blank at fall", dout_en, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 15'd5, 8'h77);
    sample();
    chk("R4 blank held", dout_en, 1'b0);
    idle(2);

    // R6: manual switch
    @(negedge clk); protect_sw = 1'b1;
    write_at(15'd5, 8'h00);
    read_at(15'd5);
    chk("R6 read ok", dout_en, 1'b1);
    chk("R6 byte kept", dout, 8'h77);
    idle(1);
    @(negedge clk); protect_sw = 1'b0;

    // R10: address above fitted width
    read_at(15'h0803);
    chk("R10 flag high", addr_err, 1'b1);
    drive(1'b1, 1'b1, 1'b1, 15'h4800, '0);
    sample();
    chk("R10 flag needs ce", addr_err, 1'b0);
    idle(1);

    // R5: supply low ignores reads and writes
    write_at(15'd6, 8'h12);
    idle(1);
    @(negedge clk); supply_ok = 1'b0;
    read_at(15'd5);
    chk("R5 no drive", dout_en, 1'b0);
    write_at(15'd5, 8'hEE);
    idle(2);
    @(negedge clk); supply_ok = 1'b1;
    idle(REC + 4);
    read_at(15'd5);
    chk("R5 write ignored", dout, 8'h77);
    idle(1);

    // R5: pulse cut off by supply drop
    drive(1'b0, 1'b1, 1'b0, 15'd6, 8'h99);
    @(negedge clk); supply_ok = 1'b0;
    idle(2);
    @(negedge clk); supply_ok = 1'b1;
    idle(REC + 4);
    read_at(15'd6);
    chk("R5 aborted write", dout, 8'h12);
    idle(1);

    // R8: both cells weak, read in the second cycle
    power_cycle(1'b0, 1'b0);
    read_at(15'd5);
    chk("R8 first cycle", dout_en, 1'b1);
    idle(1);
    read_at(15'd5);
    chk("R8 second dropped", dout_en, 1'b0);
    idle(1);
    read_at(15'd5);
    chk("R8 third cycle", dout_en, 1'b1);
    chk("R8 third byte", dout, 8'h77);
    idle(1);

    // R8: write placed in the dropped slot
    power_cycle(1'b0, 1'b0);
    read_at(15'd5);
    idle(1);
    write_at(15'd5, 8'h44);
    read_at(15'd5);
    chk("R8 write dropped", dout, 8'h77);
    idle(1);

    // R9: one good cell
    power_cycle(1'b1, 1'b0);
    read_at(15'd5);
    idle(1);
    read_at(15'd5);
    chk("R9 second kept", dout_en, 1'b1);
    chk("R9 second byte", dout, 8'h77);
    idle(2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule